// File: doc/BRIEF.md
# Banked Cluster Memory with Load-Reserved / Store-Conditional

This block is the shared word memory of a processing cluster. Eight processing-element (PE) ports reach four banks, and the banks are interleaved on consecutive 32-bit words. Each bank has its own round-robin arbiter, so PEs that target different banks are served in the same cycle. Each PE request carries one of four operations. A plain load and a plain store behave as usual. A load-reserved (LR) returns a word and records a reservation. A store-conditional (SC) writes only if the issuing PE still holds a reservation on that bank, and it returns a success or failure code instead of data.

Reservations are tracked at the banks and not at the requesters. Each bank keeps one reservation bit per PE. Any number of PEs may reserve the same bank together, and one PE may hold reservations on several banks. The check for an SC happens at the bank in the cycle the SC is granted. Because of this, two SCs that race to one bank are ordered by its arbiter: the first one succeeds and clears the bank's reservations, so the second one fails.

A separate 32-byte network write port fills one aligned line across all four banks in a single cycle. It has priority over every PE, and it drops all reservations in the cluster.

Top module: `lrsc_cluster_mem`

## Requirements
- R1: A word at byte address A is held in bank A[3:2] at row A[14:4]. A load returns the word last stored there. Requests to different banks are granted in the same cycle.
- R2: Operation codes are 00 load, 01 store, 10 LR and 11 SC. For each accepted load, LR or SC, `pe_rsp_valid` of that PE is high for one cycle, exactly one cycle after the accepting clock edge. A store produces no response.
- R3: An LR returns the addressed word like a load and gives the issuing PE a reservation on that bank.
- R4: A plain store to a bank removes the reservations of all PEs on that bank.
- R5: An SC from a PE that holds a reservation on the bank writes its data and returns the word 0. It then removes every reservation on that bank.
- R6: An SC from a PE that holds no reservation on the bank returns the word 1. It writes nothing and leaves that bank's reservations as they were.
- R7: A network write stores the eight words of 32-byte line L at byte addresses 32L to 32L+28. In that cycle it blocks every PE request (ready low), and it removes all reservations in all banks.
- R8: A plain load never changes any reservation.
- R9: Reservations in different banks are independent. An LR to one bank does not remove the same PE's reservation on another bank.
- R10: Two SCs to the same bank presented in the same cycle are granted in different cycles. If both PEs held reservations, the first granted succeeds (0) and the second fails (1).
- R11: Each bank grants at most one PE per cycle in round-robin order. With N PEs requesting the same bank, all of them are served within N consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pe_req_valid | input | 8 | Request valid, one bit per PE |
| pe_req_op | input | 16 | Two-bit operation code per PE (PE p at bits 2p+1:2p) |
| pe_req_addr | input | 120 | 15-bit byte address per PE |
| pe_req_wdata | input | 256 | 32-bit write data per PE |
| pe_req_ready | output | 8 | Request accepted at the next rising edge |
| pe_rsp_valid | output | 8 | Response valid per PE |
| pe_rsp_data | output | 256 | 32-bit read data or SC code per PE |
| net_wr_valid | input | 1 | Network line write this cycle |
| net_wr_line | input | 10 | Index of the 32-byte line |
| net_wr_data | input | 256 | Line data, word j at bits 32j+31:32j |

## Verification
The hardest case to reach from the ports is a true race: two PEs that both hold a reservation on one bank, with SCs presented in the same cycle, so that only the bank's grant order decides the winner. The bench posts both LRs together, then posts both SCs together. Its scoreboard model processes grants in the order the ready signals reveal them and expects exactly one success. A second hard case is a PE request held off by a network write. The bench presents a load in the same cycle as the line write and checks that ready stays low and no response appears.

// File: rtl/lrsc_pkg.sv
`timescale 1ns/1ps
package lrsc_pkg;
  localparam int WORD_W = 32;
  localparam int LINE_BYTES = 32;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LR    = 2'b10,
    OP_SC    = 2'b11
  } mem_op_e;
endpackage

// File: rtl/lrsc_rr_arb.sv
`timescale 1ns/1ps
module lrsc_rr_arb #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          block,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  logic [IW-1:0] last_q, last_d;

  // Search starts just after the last winner, so the winner drops to lowest priority.
  always_comb begin
    gnt     = '0;
    gnt_idx = last_q;
    gnt_any = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last_q) + k) % N;
      if (!block && !gnt_any && req[idx]) begin
        gnt[idx] = 1'b1;
        gnt_idx  = IW'(idx);
        gnt_any  = 1'b1;
      end
    end
    last_d = gnt_any ? gnt_idx : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= IW'(N - 1);
    end else if (gnt_any) begin
      last_q <= last_d;
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R11
  AST_GNT_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0); // R11
  AST_BLOCK_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    block |-> (gnt == '0)); // R7
endmodule

// File: rtl/lrsc_resv.sv
`timescale 1ns/1ps
module lrsc_resv
  import lrsc_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all,
  input  logic          acc_valid,
  input  mem_op_e       acc_op,
  input  logic [IW-1:0] acc_pe,
  output logic          sc_ok
);
  logic [N-1:0] held_q, held_d;
  logic         held_en;

  assign sc_ok   = held_q[acc_pe];
  assign held_en = clr_all | acc_valid;

  always_comb begin
    held_d = held_q;
    if (clr_all) begin
      held_d = '0;
    end else if (acc_valid) begin
      unique case (acc_op)
        OP_LR:    held_d[acc_pe] = 1'b1;
        OP_STORE: held_d = '0;
        OP_SC:    if (held_q[acc_pe]) held_d = '0;
        default:  held_d = held_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (held_en) begin
      held_q <= held_d;
    end
  end

  AST_LR_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_op == OP_LR && !clr_all) |=> held_q[$past(acc_pe)]); // R3
  AST_STORE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_op == OP_STORE) |=> (held_q == '0)); // R4
  AST_SC_WIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_op == OP_SC && sc_ok) |=> (held_q == '0)); // R5
  AST_SC_LOSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_op == OP_SC && !sc_ok && !clr_all) |=> $stable(held_q)); // R6
  AST_NET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (held_q == '0)); // R7
  AST_LOAD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_op == OP_LOAD && !clr_all) |=> $stable(held_q)); // R8
endmodule

// File: rtl/lrsc_bank.sv
`timescale 1ns/1ps
module lrsc_bank
  import lrsc_pkg::*;
#(
  parameter int N_PE   = 8,
  parameter int ROWS   = 2048,
  parameter int HALVES = 2,
  localparam int IW     = $clog2(N_PE),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int HSEL_W = $clog2(HALVES),
  localparam int LINE_W = ROW_W - HSEL_W,
  localparam int DEPTH  = ROWS / HALVES
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [N_PE-1:0]                   req,
  input  logic [N_PE-1:0][1:0]              op,
  input  logic [N_PE-1:0][ROW_W-1:0]        row,
  input  logic [N_PE-1:0][WORD_W-1:0]       wdata,
  input  logic                              net_valid,
  input  logic [LINE_W-1:0]                 net_line,
  input  logic [HALVES-1:0][WORD_W-1:0]     net_data,
  output logic [N_PE-1:0]                   gnt,
  output logic                              rsp_valid,
  output logic [IW-1:0]                     rsp_pe,
  output logic [WORD_W-1:0]                 rsp_data
);
  logic [IW-1:0]     g_idx;
  logic              g_any;
  mem_op_e           g_op;
  logic [ROW_W-1:0]  g_row;
  logic [WORD_W-1:0] g_wdata;
  logic [HSEL_W-1:0] g_half;
  logic [LINE_W-1:0] g_line;
  logic              sc_ok;
  logic              do_write;

  lrsc_rr_arb #(.N(N_PE)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .block   (net_valid),
    .gnt     (gnt),
    .gnt_idx (g_idx),
    .gnt_any (g_any)
  );

  assign g_op    = mem_op_e'(op[g_idx]);
  assign g_row   = row[g_idx];
  assign g_wdata = wdata[g_idx];
  assign g_half  = g_row[HSEL_W-1:0];
  assign g_line  = g_row[ROW_W-1:HSEL_W];

  lrsc_resv #(.N(N_PE)) u_resv (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (net_valid),
    .acc_valid (g_any),
    .acc_op    (g_op),
    .acc_pe    (g_idx),
    .sc_ok     (sc_ok)
  );

  assign do_write = g_any && ((g_op == OP_STORE) || (g_op == OP_SC && sc_ok));

  logic [WORD_W-1:0] rd_word [HALVES];

  // One storage array per line half, so a network line writes every half at once.
  for (genvar h = 0; h < HALVES; h++) begin : g_half_mem
    logic [WORD_W-1:0] mem [DEPTH];
    logic              wr_en;
    logic [LINE_W-1:0] wr_line;
    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] rd_q;

    always_comb begin
      if (net_valid) begin
        wr_en   = 1'b1;
        wr_line = net_line;
        wr_word = net_data[h];
      end else begin
        wr_en   = do_write && (g_half == HSEL_W'(h));
        wr_line = g_line;
        wr_word = g_wdata;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en) begin
        mem[wr_line] <= wr_word;
      end
      if (g_any) begin
        rd_q <= mem[g_line];
      end
    end

    assign rd_word[h] = rd_q;
  end

  logic              rv_q, rv_d;
  logic [IW-1:0]     rpe_q;
  logic              rsc_q;
  logic              rcode_q;
  logic [HSEL_W-1:0] rhalf_q;

  assign rv_d = g_any && (g_op != OP_STORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q    <= 1'b0;
      rpe_q   <= '0;
      rsc_q   <= 1'b0;
      rcode_q <= 1'b0;
      rhalf_q <= '0;
    end else begin
      rv_q <= rv_d;
      if (g_any) begin
        rpe_q   <= g_idx;
        rsc_q   <= (g_op == OP_SC);
        rcode_q <= !sc_ok;
        rhalf_q <= g_half;
      end
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_pe    = rpe_q;
  assign rsp_data  = rsc_q ? {{(WORD_W-1){1'b0}}, rcode_q} : rd_word[rhalf_q];

  AST_RSP_FOLLOWS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(g_any)); // R2
  AST_NET_BLOCKS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    net_valid |-> !rv_d); // R7
endmodule

// File: rtl/lrsc_cluster_mem.sv
`timescale 1ns/1ps
module lrsc_cluster_mem
  import lrsc_pkg::*;
#(
  parameter int N_PE      = 8,
  parameter int N_BANK    = 4,
  parameter int MEM_BYTES = 32768,
  localparam int ADDR_W   = $clog2(MEM_BYTES),
  localparam int LINE_W   = ADDR_W - $clog2(LINE_BYTES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_PE-1:0]            pe_req_valid,
  input  logic [N_PE*2-1:0]          pe_req_op,
  input  logic [N_PE*ADDR_W-1:0]     pe_req_addr,
  input  logic [N_PE*WORD_W-1:0]     pe_req_wdata,
  output logic [N_PE-1:0]            pe_req_ready,
  output logic [N_PE-1:0]            pe_rsp_valid,
  output logic [N_PE*WORD_W-1:0]     pe_rsp_data,
  input  logic                       net_wr_valid,
  input  logic [LINE_W-1:0]          net_wr_line,
  input  logic [LINE_BYTES*8-1:0]    net_wr_data
);
  localparam int IW         = $clog2(N_PE);
  localparam int BSEL_W     = $clog2(N_BANK);
  localparam int WORDS      = MEM_BYTES / 4;
  localparam int ROWS       = WORDS / N_BANK;
  localparam int ROW_W      = $clog2(ROWS);
  localparam int LINE_WORDS = LINE_BYTES / 4;
  localparam int HALVES     = LINE_WORDS / N_BANK;

  // Reset: asserted at once, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_s = rst_sync_q[1];

  logic [N_PE-1:0][BSEL_W-1:0] pe_bank;
  logic [N_PE-1:0][ROW_W-1:0]  pe_row;
  logic [N_PE-1:0][1:0]        pe_op;
  logic [N_PE-1:0][WORD_W-1:0] pe_wd;
  logic [N_PE-1:0][1:0]        pe_addr_unused;

  for (genvar p = 0; p < N_PE; p++) begin : g_pe_split
    assign pe_bank[p]        = pe_req_addr[p*ADDR_W+2 +: BSEL_W];
    assign pe_row[p]         = pe_req_addr[p*ADDR_W+2+BSEL_W +: ROW_W];
    assign pe_addr_unused[p] = pe_req_addr[p*ADDR_W +: 2];
    assign pe_op[p]          = pe_req_op[p*2 +: 2];
    assign pe_wd[p]          = pe_req_wdata[p*WORD_W +: WORD_W];
  end

  logic [N_BANK-1:0][N_PE-1:0]   bank_req;
  logic [N_BANK-1:0][N_PE-1:0]   bank_gnt;
  logic [N_BANK-1:0]             bank_rsp_v;
  logic [N_BANK-1:0][IW-1:0]     bank_rsp_pe;
  logic [N_BANK-1:0][WORD_W-1:0] bank_rsp_data;

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic [HALVES-1:0][WORD_W-1:0] nd;

    for (genvar p = 0; p < N_PE; p++) begin : g_req
      assign bank_req[b][p] = pe_req_valid[p] && (pe_bank[p] == BSEL_W'(b));
    end

    // Line word j lands in bank j mod N_BANK, half j / N_BANK.
    for (genvar h = 0; h < HALVES; h++) begin : g_net
      assign nd[h] = net_wr_data[(h*N_BANK+b)*WORD_W +: WORD_W];
    end

    lrsc_bank #(.N_PE(N_PE), .ROWS(ROWS), .HALVES(HALVES)) u_bank (
      .clk       (clk),
      .rst_n     (rst_s),
      .req       (bank_req[b]),
      .op        (pe_op),
      .row       (pe_row),
      .wdata     (pe_wd),
      .net_valid (net_wr_valid),
      .net_line  (net_wr_line),
      .net_data  (nd),
      .gnt       (bank_gnt[b]),
      .rsp_valid (bank_rsp_v[b]),
      .rsp_pe    (bank_rsp_pe[b]),
      .rsp_data  (bank_rsp_data[b])
    );
  end

  always_comb begin
    pe_req_ready = '0;
    pe_rsp_valid = '0;
    pe_rsp_data  = '0;
    for (int b = 0; b < N_BANK; b++) begin
      pe_req_ready = pe_req_ready | bank_gnt[b];
      if (bank_rsp_v[b]) begin
        pe_rsp_valid[bank_rsp_pe[b]] = 1'b1;
        pe_rsp_data[int'(bank_rsp_pe[b])*WORD_W +: WORD_W] = bank_rsp_data[b];
      end
    end
  end

  for (genvar p = 0; p < N_PE; p++) begin : g_chk
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_s)
      pe_rsp_valid[p] |-> $past(pe_req_valid[p] && pe_req_ready[p]
                                && pe_req_op[p*2 +: 2] != 2'(OP_STORE))); // R2
    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_s)
      pe_req_ready[p] |-> pe_req_valid[p]); // R11
    AST_NET_HOLDS_PE: assert property (@(posedge clk) disable iff (!rst_s)
      net_wr_valid |-> !pe_req_ready[p]); // R7
  end
endmodule

// File: tb/sim_lrsc_cluster_mem.sv
`timescale 1ns/1ps
module sim_lrsc_cluster_mem;
  localparam int NP = 8;
  localparam int AW = 15;
  localparam logic [1:0] LD = 2'b00, ST = 2'b01, LR = 2'b10, SC = 2'b11;

  logic clk, rst_n;
  logic [NP-1:0]    pe_req_valid;
  logic [NP*2-1:0]  pe_req_op;
  logic [NP*AW-1:0] pe_req_addr;
  logic [NP*32-1:0] pe_req_wdata;
  logic [NP-1:0]    pe_req_ready;
  logic [NP-1:0]    pe_rsp_valid;
  logic [NP*32-1:0] pe_rsp_data;
  logic             net_wr_valid;
  logic [9:0]       net_wr_line;
  logic [255:0]     net_wr_data;

  lrsc_cluster_mem u0 (
    .clk(clk), .rst_n(rst_n),
    .pe_req_valid(pe_req_valid), .pe_req_op(pe_req_op),
    .pe_req_addr(pe_req_addr), .pe_req_wdata(pe_req_wdata),
    .pe_req_ready(pe_req_ready), .pe_rsp_valid(pe_rsp_valid),
    .pe_rsp_data(pe_rsp_data), .net_wr_valid(net_wr_valid),
    .net_wr_line(net_wr_line), .net_wr_data(net_wr_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [31:0] data;
    int          due;
    string       tag;
  } exp_t;
  exp_t expq [NP][$];

  // Reference model of storage and reservations.
  logic [31:0] mm [int];
  bit   [3:0][NP-1:0] resv;

  bit   [NP-1:0] pend;
  logic [1:0]    s_op   [NP];
  logic [AW-1:0] s_addr [NP];
  logic [31:0]   s_wd   [NP];
  string         s_tag  [NP];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(int pe, logic [31:0] d, string tag);
    exp_t e;
    e.data = d; e.due = cyc + 1; e.tag = tag;
    expq[pe].push_back(e);
  endtask

  task automatic model_apply(int pe);
    int w, b;
    w = int'(s_addr[pe]) >> 2;
    b = w % 4;
    case (s_op[pe])
      LD: push(pe, mm[w], s_tag[pe]);
      ST: begin mm[w] = s_wd[pe]; resv[b] = '0; end
      LR: begin push(pe, mm[w], s_tag[pe]); resv[b][pe] = 1'b1; end
      default: begin
        if (resv[b][pe]) begin
          mm[w] = s_wd[pe]; resv[b] = '0; push(pe, 32'd0, s_tag[pe]);
        end else begin
          push(pe, 32'd1, s_tag[pe]);
        end
      end
    endcase
  endtask

  task automatic post(int pe, logic [1:0] op, int addr, logic [31:0] d, string tag);
    pend[pe] = 1'b1; s_op[pe] = op; s_addr[pe] = AW'(addr); s_wd[pe] = d; s_tag[pe] = tag;
  endtask

  // Driver: presents posted requests until each is accepted, feeding the model.
  task automatic run(output int ncyc);
    bit [NP-1:0] acc;
    ncyc = 0;
    while (pend != '0 && ncyc < 100) begin
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
        pe_req_valid[p] = pend[p];
        pe_req_op[p*2 +: 2] = s_op[p];
        pe_req_addr[p*AW +: AW] = s_addr[p];
        pe_req_wdata[p*32 +: 32] = s_wd[p];
      end
      #1;
      acc = pend & pe_req_ready;
      for (int p = 0; p < NP; p++) if (acc[p]) model_apply(p);
      pend = pend & ~acc;
      ncyc++;
      @(posedge clk);
    end
    @(negedge clk);
    pe_req_valid = '0;
    if (pend != '0) begin
      bad++; total++;
      $display("FAIL R11 request never accepted actual=%h expected=0", pend);
      pend = '0;
    end
  endtask

  task automatic one(int pe, logic [1:0] op, int addr, logic [31:0] d, string tag);
    int n;
    post(pe, op, addr, d, tag);
    run(n);
  endtask

  // Monitor: checks every response against the queue and its due cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < NP; p++) begin
        if (pe_rsp_valid[p]) begin
          if (expq[p].size() == 0) begin
            chk("R2 unexpected response", 32'd1, 32'd0);
          end else begin
            exp_t e;
            e = expq[p].pop_front();
            chk({e.tag, " latency"}, 32'(cyc), 32'(e.due));
            chk(e.tag, pe_rsp_data[p*32 +: 32], e.data);
          end
        end else if (expq[p].size() != 0 && expq[p][0].due <= cyc) begin
          chk({expq[p][0].tag, " missing response R2"}, 32'd0, 32'd1);
          void'(expq[p].pop_front());
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [255:0] line;
    pend = '0; resv = '0;
    pe_req_valid = '0; pe_req_op = '0; pe_req_addr = '0; pe_req_wdata = '0;
    net_wr_valid = 1'b0; net_wr_line = '0; net_wr_data = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 reset rsp_valid", 32'(pe_rsp_valid), 32'd0);
    chk("R2 reset ready", 32'(pe_req_ready), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: one word per bank plus the highest word, read back by another PE
    one(0, ST, 'h0, 32'hA000_0000, "R1");
    one(0, ST, 'h4, 32'hA111_1111, "R1");
    one(0, ST, 'h8, 32'hA222_2222, "R1");
    one(0, ST, 'hC, 32'hA333_3333, "R1");
    one(0, ST, 'h10, 32'hA444_4444, "R1");
    one(0, ST, 'h7FFC, 32'hA555_5555, "R1");
    one(3, LD, 'h0, 0, "R1 load bank0");
    one(3, LD, 'h4, 0, "R1 load bank1");
    one(3, LD, 'h8, 0, "R1 load bank2");
    one(3, LD, 'hC, 0, "R1 load bank3");
    one(3, LD, 'h10, 0, "R1 load bank0 row1");
    one(3, LD, 'h7FFC, 0, "R1 load top word");
    post(0, LD, 'h0, 0, "R1 parallel b0");
    post(1, LD, 'h4, 0, "R1 parallel b1");
    post(2, LD, 'h8, 0, "R1 parallel b2");
    run(n);
    chk("R1 parallel banks cycles", 32'(n), 32'd1);

    for (int a = 'h100; a < 'h800; a += 4) one(0, ST, a, 32'(a * 3 + 7), "R1 fill");

    // R3 / R5: LR then SC succeeds, other PE's reservation on the bank is lost
    one(2, LR, 'h120, 0, "R3 LR pe2");
    one(1, LR, 'h100, 0, "R3 LR returns word");
    one(1, SC, 'h100, 32'hC0DE_0001, "R5 SC success code");
    one(4, LD, 'h100, 0, "R5 SC wrote data");
    one(2, SC, 'h120, 32'hDEAD_0002, "R5 other reservation cleared");
    one(4, LD, 'h120, 0, "R5 failed SC no write");

    // R4: plain store to same bank kills reservation
    one(2, LR, 'h104, 0, "R4 LR");
    one(5, ST, 'h114, 32'h5151_5151, "R4 store");
    one(2, SC, 'h104, 32'hBAD0_0004, "R4 SC fails after store");
    one(2, LD, 'h104, 0, "R4 word unchanged");

    // R6: failing SC leaves other reservations intact
    one(1, LR, 'h200, 0, "R6 LR");
    one(4, SC, 'h200, 32'hBAD0_0006, "R6 SC without reservation");
    one(1, SC, 'h200, 32'h6666_0006, "R6 reservation survives failed SC");
    one(6, LD, 'h200, 0, "R6 data");

    // R8: loads do not disturb reservations
    one(1, LR, 'h300, 0, "R8 LR");
    one(6, LD, 'h310, 0, "R8 load same bank");
    one(1, LD, 'h300, 0, "R8 load own word");
    one(1, SC, 'h300, 32'h8888_0008, "R8 SC after loads");

    // R9: one PE holds reservations on two banks
    one(7, LR, 'h400, 0, "R9 LR bank0");
    one(7, LR, 'h404, 0, "R9 LR bank1");
    one(7, SC, 'h400, 32'h9999_0000, "R9 SC bank0");
    one(7, SC, 'h404, 32'h9999_0001, "R9 SC bank1");
    one(5, LD, 'h404, 0, "R9 bank1 data");

    // R10: racing SCs on one bank
    post(2, LR, 'h500, 0, "R10 LR pe2");
    post(3, LR, 'h500, 0, "R10 LR pe3");
    run(n);
    post(2, SC, 'h500, 32'h1010_0002, "R10 SC pe2");
    post(3, SC, 'h500, 32'h1010_0003, "R10 SC pe3");
    run(n);
    chk("R10 SCs serialized cycles", 32'(n), 32'd2);
    one(0, LD, 'h500, 0, "R10 winner data");

    // R11: all PEs on one bank
    for (int p = 0; p < NP; p++) post(p, LD, 'h600, 0, "R11 shared load");
    run(n);
    chk("R11 eight requesters cycles", 32'(n), 32'd8);

    // R7: network line write
    one(0, LR, 'h608, 0, "R7 LR before net");
    for (int j = 0; j < 8; j++) line[j*32 +: 32] = 32'hCE00_0000 + 32'(j);
    @(negedge clk);
    net_wr_valid = 1'b1; net_wr_line = 10'd3; net_wr_data = line;
    pe_req_valid[5] = 1'b1; pe_req_op[10 +: 2] = LD; pe_req_addr[5*AW +: AW] = 'h64;
    #1;
    chk("R7 ready held low", 32'(pe_req_ready), 32'd0);
    for (int j = 0; j < 8; j++) mm[24 + j] = line[j*32 +: 32];
    resv = '0;
    @(posedge clk);
    @(negedge clk);
    net_wr_valid = 1'b0; pe_req_valid = '0;
    for (int j = 0; j < 8; j++) one(5, LD, 'h60 + 4 * j, 0, "R7 line word");
    one(0, SC, 'h608, 32'hBAD0_0007, "R7 reservation dropped");

    repeat (5) @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) chk("R2 queue drained", 32'(expq[p].size()), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule